// File: doc/BRIEF.md
# Sticky Event Status Register

This block gathers single-cycle event pulses from an instrument controller's message handling and execution logic into an eight-bit status byte. Each bit latches its event and holds it until host software reads the byte through a read strobe, or issues a clear-status command. An enable mask, written separately and never touched by clear-status, selects which latched bits drive one summary output. That output is meant for the service-request logic.

The block also owns the operation-complete mechanism. An arm command sets a flag. Bit 0 then latches as soon as every selected pending operation has finished, and the flag drops so that one arm gives one report. A small tracker marks operations busy from start to done, and a mask input chooses which of them hold off the report. Three query-protocol violation inputs feed the query-error bit. Device faults and execution failures feed their own bits. Clear-status also sends a one-cycle clear pulse toward the error queue.

Top module: `sticky_evt_stat`

## Requirements
- R1: After reset the event byte, the enable mask, the summary output and the error-queue clear pulse are all zero, and operation-complete is not armed.
- R2: A latched event bit stays set for as long as neither a read strobe nor clear-status occurs.
- R3: A read strobe leaves every bit zero after the clock edge, except bits whose event pulse arrives in that same cycle. The set wins over the clear, and the same rule holds for clear-status.
- R4: Bit 0 (operation complete) sets one cycle after the arm flag is set and all selected pending operations are idle. The flag is set by the arm command and drops when bit 0 is set, so bit 0 does not set again without a new arm command.
- R5: A pending slot is busy from its start pulse until its done pulse, and a start wins over a done in the same cycle. Only slots whose mask bit is 1 hold off operation complete.
- R6: Bit 2 (query error) sets on any of three inputs: a response interrupted by a new message, a read before the full query arrived, or a deadlock with both buffers full.
- R7: Bit 3 sets on a device fault pulse. Bit 4 sets on an execution error pulse.
- R8: Bit 1 always reads zero. Bits 5, 6 and 7 are set by reserved input bits 0, 1 and 2.
- R9: An enable write loads the mask. The summary output is 1 exactly when some bit is set in both the event byte and the mask, and it follows both with no extra delay.
- R10: Clear-status zeroes the event bits, disarms operation complete (winning over an arm command in the same cycle) and raises the error-queue clear output for the following cycle. It leaves the mask unchanged, but an enable write in the same cycle still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_opc_i | input | 1 | Operation-complete arm command pulse |
| pend_start_i | input | NUM_PEND | Pending operation start pulses, one per slot |
| pend_done_i | input | NUM_PEND | Pending operation done pulses, one per slot |
| pend_sel_i | input | NUM_PEND | Slots that hold off operation complete |
| qry_intr_i | input | 1 | Response interrupted by new message |
| qry_unterm_i | input | 1 | Read attempted before full query received |
| qry_dlock_i | input | 1 | Buffers full, parser and execution blocked |
| dev_fault_i | input | 1 | Internal device fault pulse |
| exec_fail_i | input | 1 | Command could not be executed pulse |
| rsv_evt_i | input | 3 | Reserved event pulses for bits 5 to 7 |
| rd_stb_i | input | 1 | Read strobe; clears the byte after the edge |
| clr_stat_i | input | 1 | Clear-status command pulse |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 8 | Enable mask write data |
| evt_o | output | 8 | Current event byte (read data) |
| en_o | output | 8 | Current enable mask |
| summary_o | output | 1 | OR of event byte AND enable mask |
| errq_clr_o | output | 1 | One-cycle error-queue clear pulse |

## Verification
A corrupted latch shows on `evt_o` one edge after the faulty update: a lost bit, a bit that survives a read, or a bit that never appears. A wrong arm flag or busy flag shows as a missing or repeated bit 0. It can also show as a bit 0 that appears while a selected slot is still busy, which is visible two edges after the arm command or the done pulse. A damaged mask shows on `en_o` and `summary_o` in the same cycle as the event byte it gates.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;

    localparam int EVT_W  = 8;
    localparam int B_OPC  = 0;
    localparam int B_RQC  = 1;
    localparam int B_QYE  = 2;
    localparam int B_DDE  = 3;
    localparam int B_EXE  = 4;
    localparam int B_RSV  = 5;
    localparam int RSV_W  = EVT_W - B_RSV;

    typedef logic [EVT_W-1:0] evt_vec_t;

endpackage

// File: rtl/pend_tracker.sv
module pend_tracker #(
    parameter int NUM_PEND = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PEND-1:0] start_i,
    input  logic [NUM_PEND-1:0] done_i,
    input  logic [NUM_PEND-1:0] sel_i,
    output logic                all_idle_o
);

    typedef struct packed {
        logic [NUM_PEND-1:0] busy;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = (st_q.busy & ~done_i) | start_i;
        all_idle_o = ((st_q.busy & sel_i) == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < NUM_PEND; s++) begin : g_slot_chk
        // R5: a start pulse marks the slot busy
        a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
            start_i[s] |=> st_q.busy[s]);
        // R5: a done pulse without a start frees the slot
        a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i[s] && !start_i[s]) |=> !st_q.busy[s]);
    end

endmodule

// File: rtl/opc_ctrl.sv
module opc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clr_i,
    input  logic all_idle_i,
    output logic fire_o,
    output logic armed_o
);

    typedef struct packed {
        logic armed;
    } opc_st_t;

    opc_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = st_q.armed && all_idle_i;
        if (clr_i) begin
            st_d.armed = 1'b0;
        end else if (arm_i) begin
            st_d.armed = 1'b1;
        end else if (fire_o) begin
            st_d.armed = 1'b0;
        end
        armed_o = st_q.armed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: once reported, the flag drops unless re-armed
    a_r4_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && all_idle_i && !arm_i) |=> !st_q.armed);
    // R10: clear-status always disarms
    a_r10_clr_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !st_q.armed);

endmodule

// File: rtl/evt_bank.sv
module evt_bank
    import evt_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t set_i,
    input  logic     rd_i,
    input  logic     clr_i,
    output evt_vec_t evt_o
);

    typedef struct packed {
        evt_vec_t evt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     wipe;

    always_comb begin
        st_d   = st_q;
        wipe   = rd_i || clr_i;
        st_d.evt = (wipe ? '0 : st_q.evt) | set_i;
        evt_o  = st_q.evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit_chk
        // R2: a latched bit holds without a read or clear
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.evt[b] && !rd_i && !clr_i) |=> st_q.evt[b]);
        // R3: an event in the same cycle as a clear is kept
        a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> st_q.evt[b]);
    end

    // R3: a read with no new events empties the byte
    a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || clr_i) && set_i == '0) |=> (st_q.evt == '0));

endmodule

// File: rtl/sticky_evt_stat.sv
module sticky_evt_stat
    import evt_stat_pkg::*;
#(
    parameter int NUM_PEND = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_opc_i,
    input  logic [NUM_PEND-1:0] pend_start_i,
    input  logic [NUM_PEND-1:0] pend_done_i,
    input  logic [NUM_PEND-1:0] pend_sel_i,
    input  logic                qry_intr_i,
    input  logic                qry_unterm_i,
    input  logic                qry_dlock_i,
    input  logic                dev_fault_i,
    input  logic                exec_fail_i,
    input  logic [2:0]          rsv_evt_i,
    input  logic                rd_stb_i,
    input  logic                clr_stat_i,
    input  logic                en_wr_i,
    input  logic [7:0]          en_wdata_i,
    output logic [7:0]          evt_o,
    output logic [7:0]          en_o,
    output logic                summary_o,
    output logic                errq_clr_o
);

    typedef struct packed {
        evt_vec_t en;
        logic     errq_clr;
    } top_st_t;

    top_st_t  st_d, st_q;
    evt_vec_t set_vec;
    evt_vec_t evt_q;
    logic     all_idle;
    logic     opc_fire;
    logic     opc_armed;

    pend_tracker #(.NUM_PEND(NUM_PEND)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (pend_start_i),
        .done_i     (pend_done_i),
        .sel_i      (pend_sel_i),
        .all_idle_o (all_idle)
    );

    opc_ctrl i_opc (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_opc_i),
        .clr_i      (clr_stat_i),
        .all_idle_i (all_idle),
        .fire_o     (opc_fire),
        .armed_o    (opc_armed)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[B_OPC] = opc_fire;
        set_vec[B_RQC] = 1'b0;
        set_vec[B_QYE] = qry_intr_i || qry_unterm_i || qry_dlock_i;
        set_vec[B_DDE] = dev_fault_i;
        set_vec[B_EXE] = exec_fail_i;
        for (int r = 0; r < RSV_W; r++) begin
            set_vec[B_RSV + r] = rsv_evt_i[r];
        end
    end

    evt_bank i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .rd_i  (rd_stb_i),
        .clr_i (clr_stat_i),
        .evt_o (evt_q)
    );

    always_comb begin
        st_d          = st_q;
        st_d.errq_clr = clr_stat_i;
        if (en_wr_i) begin
            st_d.en = en_wdata_i;
        end
        evt_o      = evt_q;
        en_o       = st_q.en;
        summary_o  = |(evt_q & st_q.en);
        errq_clr_o = st_q.errq_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: clear-status does not disturb the mask
    a_r10_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat_i && !en_wr_i) |=> $stable(en_o));
    // R10: queue clear pulse follows the command by one cycle
    a_r10_errq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat_i |=> errq_clr_o);
    // R4: an armed controller never reports while a selected slot is busy
    a_r4_no_early_opc: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_o[B_OPC] && !all_idle) |=> !evt_o[B_OPC]);
    // R8: unused bit stays low in the register
    a_r8_rqc_low: assert property (@(posedge clk) disable iff (!rst_n)
        opc_armed || !opc_armed |-> !evt_o[B_RQC]);

endmodule

// File: tb/test_sticky_evt_stat.sv
`timescale 1ns/1ps
module test_sticky_evt_stat;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_opc = 1'b0;
    logic [NP-1:0] pstart = '0, pdone = '0, psel = '1;
    logic          qintr = 1'b0, qunt = 1'b0, qdl = 1'b0;
    logic          dfault = 1'b0, xfail = 1'b0;
    logic [2:0]    rsv = '0;
    logic          rd = 1'b0, clr = 1'b0, enwr = 1'b0;
    logic [7:0]    enwd = '0;
    logic [7:0]    evt, en;
    logic          summ, errq;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    typedef struct {
        logic [7:0] evt;
        logic [7:0] en;
        logic       sum;
        logic       errq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    sticky_evt_stat #(.NUM_PEND(NP)) i_sticky_evt_stat (
        .clk(clk), .rst_n(rst_n), .arm_opc_i(arm_opc),
        .pend_start_i(pstart), .pend_done_i(pdone), .pend_sel_i(psel),
        .qry_intr_i(qintr), .qry_unterm_i(qunt), .qry_dlock_i(qdl),
        .dev_fault_i(dfault), .exec_fail_i(xfail), .rsv_evt_i(rsv),
        .rd_stb_i(rd), .clr_stat_i(clr), .en_wr_i(enwr), .en_wdata_i(enwd),
        .evt_o(evt), .en_o(en), .summary_o(summ), .errq_clr_o(errq)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick(input logic [7:0] e_evt, input logic [7:0] e_en,
                        input logic e_sum, input logic e_errq, input string tag);
        exp_t e;
        e.evt = e_evt; e.en = e_en; e.sum = e_sum; e.errq = e_errq; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        arm_opc = 0; pstart = '0; pdone = '0; qintr = 0; qunt = 0; qdl = 0;
        dfault = 0; xfail = 0; rsv = '0; rd = 0; clr = 0; enwr = 0;
    endtask

    // monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(evt == e.evt, {e.tag, " evt"}, evt, e.evt);
                chk(en == e.en, {e.tag, " en"}, en, e.en);
                chk(summ == e.sum, {e.tag, " summary"}, {7'd0, summ}, {7'd0, e.sum});
                chk(errq == e.errq, {e.tag, " errq_clr"}, {7'd0, errq}, {7'd0, e.errq});
                chk(evt[1] == 1'b0, "R8 bit1 low", evt, 8'h00);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!fin) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(evt == 8'h00, "R1 reset evt", evt, 8'h00);
        chk(en == 8'h00, "R1 reset en", en, 8'h00);
        chk(summ == 1'b0 && errq == 1'b0, "R1 reset outputs", {6'd0, summ, errq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        xfail = 1; tick(8'h10, 8'h00, 0, 0, "R7 exec error");
        tick(8'h10, 8'h00, 0, 0, "R2 hold");
        tick(8'h10, 8'h00, 0, 0, "R2 hold again");
        enwr = 1; enwd = 8'h10; tick(8'h10, 8'h10, 1, 0, "R9 mask write");
        rd = 1; qintr = 1; tick(8'h04, 8'h10, 0, 0, "R6 interrupted R3 set wins");
        rd = 1; qunt = 1; tick(8'h04, 8'h10, 0, 0, "R6 unterminated");
        rd = 1; qdl = 1; tick(8'h04, 8'h10, 0, 0, "R6 deadlock");
        rd = 1; tick(8'h00, 8'h10, 0, 0, "R3 read clears");
        dfault = 1; tick(8'h08, 8'h10, 0, 0, "R7 device fault");
        rsv = 3'b101; tick(8'hA8, 8'h10, 0, 0, "R8 reserved bits");
        enwr = 1; enwd = 8'h08; tick(8'hA8, 8'h08, 1, 0, "R9 summary");
        clr = 1; tick(8'h00, 8'h08, 0, 1, "R10 clear keeps mask");
        tick(8'h00, 8'h08, 0, 0, "R10 pulse ends");
        clr = 1; enwr = 1; enwd = 8'h1F; tick(8'h00, 8'h1F, 0, 1, "R10 write with clear");

        psel = 4'b1111;
        pstart = 4'b0001; tick(8'h00, 8'h1F, 0, 0, "R5 start");
        arm_opc = 1; tick(8'h00, 8'h1F, 0, 0, "R4 armed busy");
        tick(8'h00, 8'h1F, 0, 0, "R4 held by busy");
        tick(8'h00, 8'h1F, 0, 0, "R4 held by busy");
        pdone = 4'b0001; tick(8'h00, 8'h1F, 0, 0, "R5 done");
        tick(8'h01, 8'h1F, 1, 0, "R4 opc set");
        rd = 1; tick(8'h00, 8'h1F, 0, 0, "R3 read opc");
        tick(8'h00, 8'h1F, 0, 0, "R4 one shot");
        tick(8'h00, 8'h1F, 0, 0, "R4 one shot");

        psel = 4'b1101;
        pstart = 4'b0010; tick(8'h00, 8'h1F, 0, 0, "R5 unselected start");
        arm_opc = 1; tick(8'h00, 8'h1F, 0, 0, "R4 arm");
        tick(8'h01, 8'h1F, 1, 0, "R5 unselected slot ignored");
        rd = 1; tick(8'h00, 8'h1F, 0, 0, "R3 read");

        psel = 4'b1111;
        arm_opc = 1; tick(8'h00, 8'h1F, 0, 0, "R4 arm busy");
        clr = 1; tick(8'h00, 8'h1F, 0, 1, "R10 clear");
        pdone = 4'b0010; tick(8'h00, 8'h1F, 0, 0, "R5 done");
        tick(8'h00, 8'h1F, 0, 0, "R10 disarmed");
        tick(8'h00, 8'h1F, 0, 0, "R10 disarmed");

        arm_opc = 1; clr = 1; tick(8'h00, 8'h1F, 0, 1, "R10 clear beats arm");
        tick(8'h00, 8'h1F, 0, 0, "R10 clear beats arm");

        pstart = 4'b0100; pdone = 4'b0100; tick(8'h00, 8'h1F, 0, 0, "R5 start wins");
        arm_opc = 1; tick(8'h00, 8'h1F, 0, 0, "R5 start wins");
        tick(8'h00, 8'h1F, 0, 0, "R5 still busy");
        pdone = 4'b0100; tick(8'h00, 8'h1F, 0, 0, "R5 done");
        tick(8'h01, 8'h1F, 1, 0, "R4 opc after done");

        clr = 1; xfail = 1; tick(8'h10, 8'h1F, 1, 1, "R3 set wins over clear");

        repeat (3) @(negedge clk);
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule